// File: doc/BRIEF.md
# Sigma-Delta Bitstream Receiver

This block is the front end that sits between an external sigma-delta modulator and a decimation filter. It divides the system clock by a programmable ratio to produce a clock that can drive the modulator. It then recovers the modulator's one-bit output stream and hands each recovered bit to the rest of the chip as a bit value with a one-cycle valid strobe in the system clock domain.

Two stream formats are accepted. In the clocked format, a serial clock comes with the data, and each bit is sampled on a chosen edge of that clock. The serial clock is either an external pin or the block's own generated clock. In the self-clocked format, the data line carries a Manchester-coded stream whose bit period equals the divider ratio in system cycles. Bits are recovered by timing the transitions, and either polarity convention can be selected.

A monitor watches the selected serial clock. When that clock stops toggling, the monitor raises a sticky flag that can be cleared and can be disabled.

Top module: `sd_bitstream_rx`

## Requirements
- R1: `mod_clk_o` has a period of `div_sel+1` system cycles. In each period it is high for the first floor(ratio/2) cycles and low for the rest. It is high while reset is asserted.
- R2: A `div_sel` value of 0 gives the same divide ratio of 2 as a value of 1.
- R3: When `clk_src` is 2'b00, the serial clock is the `ser_clk_i` pin. Any other value uses `mod_clk_o` internally, and `ser_clk_i` is then ignored.
- R4: With `if_mode` = 2'b00, each rising edge of the serial clock produces one valid pulse. `bit_o` carries the `ser_dat_i` level that was captured on the same system edge as the new clock level. The pulse appears three system edges after the clock change reaches the input.
- R5: With `if_mode` = 2'b01, the behaviour is the same as R4, but on falling edges of the serial clock.
- R6: With `if_mode` = 2'b10, the stream is Manchester-coded with a bit period of one divide ratio. A rising mid-bit transition yields 1 and a falling one yields 0.
- R7: With `if_mode` = 2'b11, the mid-bit polarity is inverted: a falling transition yields 1 and a rising one yields 0.
- R8: In the Manchester modes, a transition is taken as mid-bit only if at least ratio minus floor(ratio/4) cycles have passed since the last accepted one. The first transition after idle is accepted. Bit-boundary transitions produce no pulse.
- R9: `bit_vld_o` never stays high for two consecutive cycles while `if_mode` is unchanged. `bit_o` changes only together with a valid pulse.
- R10: With `ckab_en` high, `ckab_flag_o` rises once the selected serial clock has shown no level change for more than 4 times the divide ratio in system cycles. The flag then stays high until cleared.
- R11: `ckab_clr` clears the flag on the next edge. While `ckab_en` is low, the flag never sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 8 | Divide ratio minus one (0 treated as ratio 2) |
| if_mode | input | 2 | 00 clocked rising, 01 clocked falling, 10 Manchester, 11 Manchester inverted |
| clk_src | input | 2 | 00 external serial clock, otherwise internal generated clock |
| ckab_en | input | 1 | Enables the clock-absence monitor |
| ckab_clr | input | 1 | Clears the clock-absence flag |
| ser_clk_i | input | 1 | External serial clock |
| ser_dat_i | input | 1 | Serial data or Manchester stream |
| mod_clk_o | output | 1 | Generated modulator clock |
| bit_o | output | 1 | Recovered bit value |
| bit_vld_o | output | 1 | One-cycle strobe for `bit_o` |
| ckab_flag_o | output | 1 | Sticky clock-absence flag |

## Verification
The assertions check on every cycle the properties that can be judged locally:
- the valid strobe is never doubled,
- the bit output holds between strobes,
- the absence flag is sticky,
- a clear takes effect on the next edge,
- a disabled monitor cannot set the flag.

Some behaviours can only be shown by the bench's scenarios, which compare every output against a behavioural model on each clock. These are the divider waveforms for even, odd and extreme ratios, the edge and source selection, the recovery of full Manchester sequences in both polarities with boundary transitions ignored, and the exact cycle at which the absence flag rises.

// File: rtl/sd_bitstream_rx.sv
module sd_bitstream_rx #(
  parameter int DIV_W       = 8,
  parameter int TMO_PERIODS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_sel,
  input  logic [1:0]       if_mode,
  input  logic [1:0]       clk_src,
  input  logic             ckab_en,
  input  logic             ckab_clr,
  input  logic             ser_clk_i,
  input  logic             ser_dat_i,
  output logic             mod_clk_o,
  output logic             bit_o,
  output logic             bit_vld_o,
  output logic             ckab_flag_o
);
  localparam int RW = DIV_W + 1;
  localparam int GW = $clog2(TMO_PERIODS * (1 << DIV_W) + 1);

  logic [RW-1:0] ratio, half, thr, cnt, tm;
  logic [GW-1:0] gap, limit;
  logic [2:0]    ck_sh, dt_sh;
  logic          sel_ck, edge_any, rise, fall, dtr, take;
  logic          bit_q, vld_q, flag_q;

  assign ratio = (div_sel == '0) ? RW'(2) : RW'(div_sel) + RW'(1);
  assign half  = ratio >> 1;
  assign thr   = ratio - (ratio >> 2);
  assign limit = GW'(TMO_PERIODS) * GW'(ratio);

  assign mod_clk_o = cnt < half;
  assign sel_ck    = (clk_src == 2'b00) ? ser_clk_i : mod_clk_o;

  assign edge_any = ck_sh[1] ^ ck_sh[2];
  assign rise     = ck_sh[1] & ~ck_sh[2];
  assign fall     = ~ck_sh[1] & ck_sh[2];
  assign dtr      = dt_sh[1] ^ dt_sh[2];
  assign take     = if_mode[1] ? (dtr && tm >= thr) : (if_mode[0] ? fall : rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      ck_sh  <= '0;
      dt_sh  <= '0;
      tm     <= '1;
      gap    <= '0;
      flag_q <= 1'b0;
      bit_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      cnt   <= (cnt >= ratio - RW'(1)) ? '0 : cnt + RW'(1);
      ck_sh <= {ck_sh[1:0], sel_ck};
      dt_sh <= {dt_sh[1:0], ser_dat_i};
      vld_q <= take;
      if (take) bit_q <= dt_sh[1] ^ (if_mode[1] & if_mode[0]);
      if (if_mode[1] && take) tm <= RW'(1);
      else if (tm != '1)      tm <= tm + RW'(1);
      gap    <= (!ckab_en || edge_any) ? '0 : ((gap < limit) ? gap + GW'(1) : gap);
      flag_q <= ckab_clr ? 1'b0 : (flag_q | (ckab_en && gap >= limit));
    end
  end

  assign bit_o       = bit_q;
  assign bit_vld_o   = vld_q;
  assign ckab_flag_o = flag_q;
endmodule

// File: rtl/sd_bitstream_rx_chk.sv
module sd_bitstream_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] if_mode,
  input logic       ckab_en,
  input logic       ckab_clr,
  input logic       bit_o,
  input logic       bit_vld_o,
  input logic       ckab_flag_o
);
  p_vld_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld_o |=> (!bit_vld_o || !$stable(if_mode)));

  p_bit_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bit_o) |-> bit_vld_o);

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ckab_flag_o && !ckab_clr) |=> ckab_flag_o);

  p_flag_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ckab_clr |=> !ckab_flag_o);

  p_flag_disabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ckab_en && !ckab_flag_o) |=> !ckab_flag_o);
endmodule

bind sd_bitstream_rx sd_bitstream_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .if_mode(if_mode), .ckab_en(ckab_en),
  .ckab_clr(ckab_clr), .bit_o(bit_o), .bit_vld_o(bit_vld_o),
  .ckab_flag_o(ckab_flag_o)
);

// File: tb/sim_sd_bitstream_rx.sv
`timescale 1ns/1ps
module sim_sd_bitstream_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] div_sel = 8'd7;
  logic [1:0] if_mode = 2'b00, clk_src = 2'b00;
  logic ckab_en = 1'b0, ckab_clr = 1'b0, ser_clk_i = 1'b0, ser_dat_i = 1'b0;
  logic mod_clk_o, bit_o, bit_vld_o, ckab_flag_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit rx[$];

  always #2.5 clk = ~clk;

  sd_bitstream_rx u0 (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .if_mode(if_mode),
    .clk_src(clk_src), .ckab_en(ckab_en), .ckab_clr(ckab_clr),
    .ser_clk_i(ser_clk_i), .ser_dat_i(ser_dat_i), .mod_clk_o(mod_clk_o),
    .bit_o(bit_o), .bit_vld_o(bit_vld_o), .ckab_flag_o(ckab_flag_o)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int  m_ph = 0, m_tm = 511, m_gap = 0;
  bit  m_flag = 0, m_bit = 0, m_vld = 0;
  bit  ckq[$] = '{0, 0, 0};
  bit  dtq[$] = '{0, 0, 0};

  function automatic int ratio_of(logic [7:0] d);
    return (d == 0) ? 2 : int'(d) + 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_tm = 511; m_gap = 0; m_flag = 0; m_bit = 0; m_vld = 0;
      ckq = '{0, 0, 0}; dtq = '{0, 0, 0};
    end else begin
      int r, lim;
      bit selc, chg, up, dn, dch, tk;
      r    = ratio_of(div_sel);
      lim  = 4 * r;
      selc = (clk_src == 2'b00) ? ser_clk_i : (m_ph < r / 2);
      chg  = ckq[1] != ckq[2];
      up   = ckq[1] && !ckq[2];
      dn   = !ckq[1] && ckq[2];
      dch  = dtq[1] != dtq[2];
      if (if_mode[1]) tk = dch && (m_tm >= r - r / 4);
      else            tk = if_mode[0] ? dn : up;
      m_vld = tk;
      if (tk) m_bit = if_mode == 2'b11 ? !dtq[1] : dtq[1];
      if (if_mode[1] && tk) m_tm = 1;
      else if (m_tm < 511) m_tm++;
      m_flag = ckab_clr ? 0 : (m_flag || (ckab_en && m_gap >= lim));
      if (!ckab_en || chg) m_gap = 0;
      else if (m_gap < lim) m_gap++;
      ckq.push_front(selc); void'(ckq.pop_back());
      dtq.push_front(ser_dat_i); void'(dtq.pop_back());
      m_ph = (m_ph >= r - 1) ? 0 : m_ph + 1;
    end
  end

  always @(negedge clk) begin
    string dt;
    dt = if_mode[1] ? (if_mode[0] ? "R7" : "R6") : (if_mode[0] ? "R5" : "R4");
    chk("R1 mod_clk", mod_clk_o, (m_ph < ratio_of(div_sel) / 2));
    chk({dt, " valid"}, bit_vld_o, m_vld);
    chk({dt, " bit"}, bit_o, m_bit);
    chk("R10 flag", ckab_flag_o, m_flag);
    if (rst_n && bit_vld_o) rx.push_back(bit_o);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL R9 watchdog expired actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic measure(int exp_per, int exp_hi, string tag);
    int hi = 0, per = 0;
    logic p;
    do begin p = mod_clk_o; tick(1); end while (!(p == 1'b0 && mod_clk_o == 1'b1));
    do begin
      if (mod_clk_o) hi++;
      per++;
      p = mod_clk_o;
      tick(1);
    end while (!(p == 1'b0 && mod_clk_o == 1'b1));
    chk({tag, " period"}, per, exp_per);
    chk({tag, " high time"}, hi, exp_hi);
  endtask

  task automatic spi_bit(bit b, bit on_fall);
    if (!on_fall) begin
      ser_dat_i = b; tick(2); ser_clk_i = 1; tick(3); ser_clk_i = 0; tick(3);
    end else begin
      ser_clk_i = 1; tick(3); ser_dat_i = b; tick(2); ser_clk_i = 0; tick(3);
    end
  endtask

  task automatic man_bit(bit b, bit inv, int r);
    bit first;
    first = !(b ^ inv);
    ser_dat_i = first;  tick(r / 2);
    ser_dat_i = !first; tick(r - r / 2);
  endtask

  task automatic cmp_rx(bit exp[$], string tag);
    chk({tag, " bit count"}, rx.size(), exp.size());
    foreach (exp[i]) if (i < rx.size()) chk({tag, " bit value"}, rx[i], exp[i]);
  endtask

  initial begin
    bit seq[$];
    int pulses;
    tick(3);
    chk("R1 reset mod_clk", mod_clk_o, 1);
    chk("R9 reset valid", bit_vld_o, 0);
    chk("R10 reset flag", ckab_flag_o, 0);
    rst_n = 1;

    div_sel = 8'd0;   tick(4); measure(2, 1, "R2 sel0");
    div_sel = 8'd1;   tick(4); measure(2, 1, "R2 sel1");
    div_sel = 8'd4;   tick(8); measure(5, 2, "R1 odd");
    div_sel = 8'd255; tick(4); measure(256, 128, "R1 max");
    div_sel = 8'd7;   tick(4); measure(8, 4, "R1 even");

    tick(5); rx.delete();
    seq = '{1, 0, 1, 1, 0, 0, 1, 0};
    foreach (seq[i]) spi_bit(seq[i], 0);
    tick(6); cmp_rx(seq, "R4 rising");

    if_mode = 2'b01; tick(6); rx.delete();
    seq = '{0, 1, 1, 0, 1};
    foreach (seq[i]) spi_bit(seq[i], 1);
    tick(6); cmp_rx(seq, "R5 falling");

    if_mode = 2'b00; clk_src = 2'b01; tick(12);
    pulses = 0;
    for (int i = 0; i < 80; i++) begin
      if (i % 3 == 0) ser_clk_i = !ser_clk_i;
      ser_dat_i = (i / 8) % 2;
      tick(1);
      if (bit_vld_o) pulses++;
    end
    chk("R3 internal clock pulses", pulses, 10);
    clk_src = 2'b00; ser_clk_i = 0; ser_dat_i = 0; tick(10);

    if_mode = 2'b10; tick(20); rx.delete();
    seq = '{1, 0, 0, 1, 1, 1, 0, 1};
    foreach (seq[i]) man_bit(seq[i], 0, 8);
    tick(20); cmp_rx(seq, "R6 R8 manchester");

    if_mode = 2'b00; ser_dat_i = 1; div_sel = 8'd11; tick(6);
    if_mode = 2'b11; tick(30); rx.delete();
    seq = '{1, 1, 0, 1, 0, 0};
    foreach (seq[i]) man_bit(seq[i], 1, 12);
    tick(30); cmp_rx(seq, "R7 R8 inverted");

    if_mode = 2'b00; div_sel = 8'd7; ser_dat_i = 0; tick(10);
    ckab_en = 1; ckab_clr = 1; tick(1); ckab_clr = 0;
    for (int i = 0; i < 10; i++) begin ser_clk_i = !ser_clk_i; tick(3); end
    chk("R10 clock present", ckab_flag_o, 0);
    tick(45);
    chk("R10 clock absent", ckab_flag_o, 1);
    tick(20);
    chk("R10 sticky", ckab_flag_o, 1);
    ckab_clr = 1; tick(1);
    chk("R11 clear", ckab_flag_o, 0);
    ckab_clr = 0; tick(2);
    chk("R10 reasserts", ckab_flag_o, 1);
    ckab_en = 0; ckab_clr = 1; tick(1); ckab_clr = 0; tick(60);
    chk("R11 disabled", ckab_flag_o, 0);
    clk_src = 2'b01; ckab_en = 1; ckab_clr = 1; tick(1); ckab_clr = 0; tick(100);
    chk("R3 internal clock monitored", ckab_flag_o, 0);

    tick(5);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule